// File: doc/BRIEF.md
# Serial Register Port for a Sixteen-Channel LED Dimmer

This block is the two-wire serial slave that a host uses to program an LED dimmer. The serial clock and data lines are oversampled by the system clock, cleaned by a synchronizer and a sample-majority filter, and decoded into START, STOP and bit events. The slave answers to a 7-bit address whose top four bits are fixed and whose low three bits come from strap pins. Once addressed, it exposes ten byte-wide registers: two read-only views of sixteen pin levels and eight read/write configuration bytes. These bytes are two blink prescalers, two duty values and four LED-source selectors. The block drives those values straight out to the dimmer core.

Every write transfer begins with a command byte. The command byte loads a 4-bit register pointer and an auto-increment flag. Later data bytes in the same transfer are written at the pointer. To read, the host writes the command byte, issues a repeated START, and reads back from the pointer. With auto-increment on, a burst walks the register file and wraps.

Top module: `ledi2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 1100 followed by strap_i[2:0]. Bit 0 selects the direction, where 1 means read and 0 means write. For any other address it leaves SDA released, and it ignores the bytes that follow until the next START.
- R2: The first byte after an acknowledged write address is the command byte. Bits 3:0 load the register pointer, bit 4 is the auto-increment flag, and bits 7:5 are ignored. After reset both the pointer and the flag are zero.
- R3: The register indices are as follows. 0 holds pins 7:0, 1 holds pins 15:8, 2 is psc0, 3 is duty0, 4 is psc1, 5 is duty1, and 6 to 9 are the LED selectors. led_sel_o[7:0] holds register 6, led_sel_o[15:8] holds register 7, led_sel_o[23:16] holds register 8 and led_sel_o[31:24] holds register 9. A data byte written to index 2 to 9 appears on the matching output.
- R4: With the flag set, the pointer advances after every data byte written or read. It goes from 9 to 0, counts 10 to 15 upward, and goes from 15 to 0. With the flag clear, the pointer stays fixed.
- R5: A data byte written to index 0 or 1 is acknowledged and changes no register.
- R6: A read of index 0 or 1 returns the current pin levels and a read of 2 to 9 returns the stored byte. Index 10 to 15 reads 00h and discards writes, which are still acknowledged.
- R7: The slave acknowledges each received byte by holding SDA low for the ninth clock. In a read it drives each data bit MSB first after SCL falls. A NACK from the master ends the read and leaves SDA released.
- R8: A START aborts any transfer in progress, at any bit, and restarts address reception. A STOP returns the slave to idle.
- R9: A low or high pulse on SCL or SDA that lasts fewer than VOTE_TAPS/2 system clocks is ignored. The default of 13 taps rejects 6-cycle pulses.
- R10: While rst_n is low, psc0, psc1 and all selectors are 00h, both duty values are 80h and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three address bits |
| pin_lvl_i | input | 16 | Pin levels returned by indices 0 and 1 |
| psc0_o | output | 8 | Prescaler register 0 |
| duty0_o | output | 8 | Duty register 0 |
| psc1_o | output | 8 | Prescaler register 1 |
| duty1_o | output | 8 | Duty register 1 |
| led_sel_o | output | 32 | Four LED selector bytes, 2 bits per LED |

## Verification
Two situations are hard to reach from the ports: a spike that the filter must swallow, and a START that lands in the middle of a byte. The bench drives both through its bit-level master. One scenario pulls SCL low for five system clocks in the middle of every high phase of a data byte. The byte must still land intact, which proves that no extra clock edge was counted. Another scenario sends three bits of a data byte and then issues a repeated START. The transfer that follows must address a different register while the first one stays untouched. Pointer wrap past 9 and past 15 is reached with bursts that start at indices 8 and 15.

// File: rtl/ledi2c_pkg.sv
package ledi2c_pkg;

    localparam int REG_COUNT   = 10;
    localparam int INPUT_REGS  = 2;
    localparam int RW_REGS     = REG_COUNT - INPUT_REGS;
    localparam int PTR_W       = 4;
    localparam int IDX_W       = $clog2(RW_REGS);
    localparam logic [3:0] ADDR_PREFIX = 4'b1100;
    localparam logic [7:0] DUTY_RESET  = 8'h80;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_RACK
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [2:0]         cnt;
        logic               full;
        logic [7:0]         sh;
        logic               rw;
        logic               nack;
        logic               ai;
        logic [PTR_W-1:0]   ptr;
        logic               oe;
        logic               scl_p;
        logic               sda_p;
    } ctrl_t;

    // pointer step: last register wraps to zero, 4-bit overflow wraps too
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(REG_COUNT - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    // reset image of the writable bytes: duty slots at odd positions
    function automatic logic [RW_REGS*8-1:0] rw_reset_image();
        logic [RW_REGS*8-1:0] img;
        img = '0;
        for (int i = 0; i < RW_REGS; i++) begin
            if (i == 1 || i == 3) img[i*8 +: 8] = DUTY_RESET;
        end
        return img;
    endfunction

endpackage

// File: rtl/ledi2c_line_filter.sv
module ledi2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = VOTE_TAPS / 2;
    localparam int CW   = $clog2(VOTE_TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [VOTE_TAPS-1:0]   win_d, win_q;
    logic                   out_d, out_q;
    logic [CW-1:0]          ones;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
        win_d  = {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
        ones   = CW'($countones(win_q));
        out_d  = (ones > CW'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            win_q  <= win_d;
            out_q  <= out_d;
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/ledi2c_regfile.sv
module ledi2c_regfile
    import ledi2c_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_ptr,
    input  logic [7:0]              wr_data,
    input  logic [PTR_W-1:0]        rd_ptr,
    input  logic [8*INPUT_REGS-1:0] pin_lvl,
    output logic [7:0]              rd_data,
    output logic [RW_REGS*8-1:0]    regs_o
);
    localparam logic [RW_REGS*8-1:0] RST_IMG = rw_reset_image();

    logic [RW_REGS*8-1:0]    regs_d, regs_q;
    logic [8*INPUT_REGS-1:0] pin_d, pin_q, pin_m_q;
    logic [IDX_W-1:0]        wr_idx, rd_idx;
    logic                    wr_hit;

    always_comb begin
        pin_d  = pin_lvl;
        wr_idx = IDX_W'(wr_ptr - PTR_W'(INPUT_REGS));
        rd_idx = IDX_W'(rd_ptr - PTR_W'(INPUT_REGS));
        wr_hit = wr_en && (wr_ptr >= PTR_W'(INPUT_REGS))
                       && (wr_ptr <  PTR_W'(REG_COUNT));
        regs_d = regs_q;
        if (wr_hit) regs_d[wr_idx*8 +: 8] = wr_data;

        rd_data = 8'h00;
        if (rd_ptr < PTR_W'(INPUT_REGS))
            rd_data = pin_q[rd_ptr[0]*8 +: 8];
        else if (rd_ptr < PTR_W'(REG_COUNT))
            rd_data = regs_q[rd_idx*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q  <= RST_IMG;
            pin_m_q <= '0;
            pin_q   <= '0;
        end else begin
            regs_q  <= regs_d;
            pin_m_q <= pin_d;
            pin_q   <= pin_m_q;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/ledi2c_ctrl.sv
module ledi2c_ctrl
    import ledi2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl,
    input  logic             sda,
    input  logic [2:0]       strap,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_ptr
);
    ctrl_t q, d;
    logic  rise, fall, start_ev, stop_ev, rx_state;

    always_comb begin
        d        = q;
        d.scl_p  = scl;
        d.sda_p  = sda;
        wr_en    = 1'b0;
        rise     = scl & ~q.scl_p;
        fall     = ~scl & q.scl_p;
        start_ev = scl & q.scl_p & q.sda_p & ~sda;
        stop_ev  = scl & q.scl_p & ~q.sda_p & sda;
        rx_state = (q.ph == ST_ADDR) || (q.ph == ST_CMD) || (q.ph == ST_WR);

        if (start_ev) begin
            d.ph   = ST_ADDR;
            d.cnt  = '0;
            d.full = 1'b0;
            d.oe   = 1'b0;
        end else if (stop_ev) begin
            d.ph   = ST_IDLE;
            d.oe   = 1'b0;
            d.full = 1'b0;
        end else if (rx_state && rise) begin
            d.sh   = {q.sh[6:0], sda};
            d.cnt  = q.cnt + 3'd1;
            d.full = (q.cnt == 3'd7);
        end else if (fall) begin
            unique case (q.ph)
                ST_ADDR: if (q.full) begin
                    d.full = 1'b0;
                    if (q.sh[7:1] == {ADDR_PREFIX, strap}) begin
                        d.rw = q.sh[0];
                        d.ph = ST_ACK_ADDR;
                        d.oe = 1'b1;
                    end else begin
                        d.ph = ST_IDLE;
                    end
                end
                ST_ACK_ADDR: begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.sh = rd_data;
                        d.oe = ~rd_data[7];
                        d.ph = ST_RD;
                    end else begin
                        d.oe = 1'b0;
                        d.ph = ST_CMD;
                    end
                end
                ST_CMD: if (q.full) begin
                    d.full = 1'b0;
                    d.ptr  = q.sh[PTR_W-1:0];
                    d.ai   = q.sh[4];
                    d.ph   = ST_ACK_CMD;
                    d.oe   = 1'b1;
                end
                ST_ACK_CMD: begin
                    d.oe = 1'b0;
                    d.ph = ST_WR;
                end
                ST_WR: if (q.full) begin
                    d.full = 1'b0;
                    wr_en  = 1'b1;
                    if (q.ai) d.ptr = step_ptr(q.ptr);
                    d.ph   = ST_ACK_WR;
                    d.oe   = 1'b1;
                end
                ST_ACK_WR: begin
                    d.oe = 1'b0;
                    d.ph = ST_WR;
                end
                ST_RD: begin
                    d.sh = {q.sh[6:0], 1'b0};
                    if (q.cnt == 3'd7) begin
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        d.ph  = ST_RACK;
                        if (q.ai) d.ptr = step_ptr(q.ptr);
                    end else begin
                        d.cnt = q.cnt + 3'd1;
                        d.oe  = ~q.sh[6];
                    end
                end
                ST_RACK: begin
                    if (q.nack) begin
                        d.ph = ST_IDLE;
                        d.oe = 1'b0;
                    end else begin
                        d.sh  = rd_data;
                        d.oe  = ~rd_data[7];
                        d.cnt = '0;
                        d.ph  = ST_RD;
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end else if (rise && q.ph == ST_RACK) begin
            d.nack = sda;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= ST_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_ptr  = q.ptr;
    assign wr_data = q.sh;
    assign rd_ptr  = q.ptr;
endmodule

// File: rtl/ledi2c_slave.sv
module ledi2c_slave
    import ledi2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  strap_i,
    input  logic [15:0] pin_lvl_i,
    output logic [7:0]  psc0_o,
    output logic [7:0]  duty0_o,
    output logic [7:0]  psc1_o,
    output logic [7:0]  duty1_o,
    output logic [31:0] led_sel_o
);
    logic [1:0]           raw_lines, clean_lines;
    logic                 wr_en;
    logic [PTR_W-1:0]     wr_ptr, rd_ptr;
    logic [7:0]           wr_data, rd_data;
    logic [RW_REGS*8-1:0] regs;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        ledi2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .VOTE_TAPS   (VOTE_TAPS)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    ledi2c_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .strap   (strap_i),
        .rd_data (rd_data),
        .sda_oe  (sda_oe_o),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr)
    );

    ledi2c_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .pin_lvl (pin_lvl_i),
        .rd_data (rd_data),
        .regs_o  (regs)
    );

    assign psc0_o    = regs[7:0];
    assign duty0_o   = regs[15:8];
    assign psc1_o    = regs[23:16];
    assign duty1_o   = regs[31:24];
    assign led_sel_o = regs[63:32];
endmodule

// File: rtl/ledi2c_checker.sv
module ledi2c_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic        wr_en,
    input logic [3:0]  wr_ptr,
    input logic [7:0]  wr_data,
    input logic [7:0]  psc0_o,
    input logic [7:0]  duty0_o,
    input logic [7:0]  psc1_o,
    input logic [7:0]  duty1_o,
    input logic [31:0] led_sel_o
);
    logic [63:0] all_regs;
    assign all_regs = {led_sel_o, duty1_o, psc1_o, duty0_o, psc0_o};

    AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i); // R7

    AST_INPUT_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr < 4'd2) |=> $stable(all_regs)); // R5

    AST_RANGE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr > 4'd9) |=> $stable(all_regs)); // R6

    AST_DUTY0_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == 4'd3) |=> duty0_o == $past(wr_data)); // R3

    AST_SEL0_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == 4'd6) |=> led_sel_o[7:0] == $past(wr_data)); // R3

    AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R7

    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_regs == 64'h0000_0000_8000_8000 && !sda_oe_o)); // R10
endmodule

bind ledi2c_slave ledi2c_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .psc0_o    (psc0_o),
    .duty0_o   (duty0_o),
    .psc1_o    (psc1_o),
    .duty1_o   (duty1_o),
    .led_sel_o (led_sel_o)
);

// File: tb/ledi2c_slave_tb_top.sv
module ledi2c_slave_tb_top;
    localparam int Q = 20;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] ADDR_W = {4'b1100, STRAP, 1'b0};
    localparam logic [7:0] ADDR_R = {4'b1100, STRAP, 1'b1};
    localparam logic [15:0] PINS = 16'hA55A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] psc0, duty0, psc1, duty1;
    logic [31:0] led_sel;
    logic [7:0] exp_regs [8];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    ledi2c_slave dut_i (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
        .sda_oe_o (sda_oe), .strap_i (STRAP), .pin_lvl_i (PINS),
        .psc0_o (psc0), .duty0_o (duty0), .psc1_o (psc1), .duty1_o (duty1),
        .led_sel_o (led_sel)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        logic [63:0] e;
        for (int i = 0; i < 8; i++) e[i*8 +: 8] = exp_regs[i];
        check(req, {led_sel, duty1, psc1, duty0, psc0}, e);
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        sda_m = b; wq(Q); scl_m = 1'b1;
        if (glitch) begin
            wq(8); scl_m = 1'b0; wq(5); scl_m = 1'b1; wq(2*Q - 13);
        end else wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~give_ack, 1'b0);
        sda_m = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R10 reset outputs", {led_sel, duty1, psc1, duty0, psc0}, 64'h0000_0000_8000_8000);
        check("R10 sda released", sda_oe, 1'b0);
    endtask

    task automatic t_burst_write();
        logic a;
        bus_start();
        send_byte(ADDR_W, 0, a); check("R1 address ack", a, 1);
        send_byte(8'h12, 0, a);  check("R2 command ack", a, 1);
        for (int i = 0; i < 8; i++) begin
            exp_regs[i] = 8'(8'h11 * (i + 1));
            send_byte(exp_regs[i], 0, a); check("R7 data ack", a, 1);
        end
        bus_stop();
        check_regs("R3 R4 burst write");
    endtask

    task automatic t_rs_read();
        logic a; logic [7:0] v;
        logic [7:0] want [5];
        want[0] = exp_regs[6]; want[1] = exp_regs[7];
        want[2] = PINS[7:0]; want[3] = PINS[15:8]; want[4] = exp_regs[0];
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h18, 0, a);
        bus_start();
        send_byte(ADDR_R, 0, a); check("R1 read address ack", a, 1);
        for (int i = 0; i < 5; i++) begin
            recv_byte(i != 4, v);
            check("R4 R6 burst read wrap", v, want[i]);
        end
        wq(4);
        check("R7 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte({4'b1100, 3'b000, 1'b0}, 0, a); check("R1 wrong address nack", a, 0);
        send_byte(8'h03, 0, a); check("R1 ignored byte nack", a, 0);
        send_byte(8'hEE, 0, a);
        bus_stop();
        check_regs("R1 no write after wrong address");
    endtask

    task automatic read_one(input logic [7:0] cmd, output logic [7:0] v);
        logic a;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(cmd, 0, a);
        bus_start();
        send_byte(ADDR_R, 0, a);
        recv_byte(0, v);
        bus_stop();
    endtask

    task automatic t_input_write();
        logic a; logic [7:0] v;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h01, 0, a);
        send_byte(8'hFF, 0, a); check("R5 input write acked", a, 1);
        bus_stop();
        check_regs("R5 input write ignored");
        read_one(8'h01, v);
        check("R5 R6 input reads pins", v, PINS[15:8]);
    endtask

    task automatic t_no_ai();
        logic a; logic [7:0] v;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h03, 0, a);
        send_byte(8'h31, 0, a);
        send_byte(8'h42, 0, a);
        bus_stop();
        exp_regs[1] = 8'h42;
        check_regs("R4 fixed pointer write");
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'hE3, 0, a);
        bus_start();
        send_byte(ADDR_R, 0, a);
        recv_byte(1, v); check("R4 fixed pointer read 1", v, 8'h42);
        recv_byte(0, v); check("R2 upper bits ignored read 2", v, 8'h42);
        bus_stop();
    endtask

    task automatic t_out_of_range();
        logic a; logic [7:0] v;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h1F, 0, a);
        send_byte(8'h77, 0, a); check("R6 out-of-range write acked", a, 1);
        send_byte(8'h5C, 0, a);
        send_byte(8'h5D, 0, a);
        send_byte(8'h99, 0, a);
        bus_stop();
        exp_regs[0] = 8'h99;
        check_regs("R4 R6 wrap from 15");
        read_one(8'h0C, v);
        check("R6 out-of-range reads zero", v, 8'h00);
    endtask

    task automatic t_glitch();
        logic a;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h04, 0, a);
        send_byte(8'h3C, 1, a); check("R9 ack with glitches", a, 1);
        bus_stop();
        exp_regs[2] = 8'h3C;
        check_regs("R9 glitch rejected");
    endtask

    task automatic t_start_abort();
        logic a;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h06, 0, a);
        put_bit(1, 0); put_bit(1, 0); put_bit(0, 0);
        bus_start();
        send_byte(ADDR_W, 0, a); check("R8 restart address ack", a, 1);
        send_byte(8'h07, 0, a);
        send_byte(8'hAB, 0, a);
        bus_stop();
        exp_regs[5] = 8'hAB;
        check_regs("R8 start aborts partial byte");
    endtask

    task automatic t_mid_reset();
        logic a;
        bus_start();
        send_byte(ADDR_W, 0, a);
        send_byte(8'h03, 0, a);
        put_bit(1, 0); put_bit(0, 0);
        rst_n = 1'b0; wq(3);
        check("R10 reset mid transfer", {led_sel, duty1, psc1, duty0, psc0}, 64'h0000_0000_8000_8000);
        check("R10 sda released in reset", sda_oe, 0);
        scl_m = 1'b1; sda_m = 1'b1; wq(Q);
        rst_n = 1'b1; wq(Q);
        for (int i = 0; i < 8; i++) exp_regs[i] = (i == 1 || i == 3) ? 8'h80 : 8'h00;
        check_regs("R10 defaults after release");
    endtask

    initial begin
        wq(10);
        t_reset_state();
        rst_n = 1'b1;
        wq(40);
        t_burst_write();
        t_rs_read();
        t_wrong_addr();
        t_input_write();
        t_no_ai();
        t_out_of_range();
        t_glitch();
        t_start_abort();
        t_mid_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule